// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a small multicycle processor that fetches its 32-bit instructions one byte at a time over an 8-bit memory path. It steps through a fixed sequence for each instruction: a fetch phase of one cycle per instruction byte, a decode cycle, and then a short path that depends on the opcode. In every cycle it drives the select, enable and write strobes of the datapath: the memory access, the instruction register byte strobes, the register file write port, the ALU operand and operation selects, and the program counter update.

The opcode input comes from the instruction register in the datapath. It is sampled only when the sequencer leaves the decode cycle and when it leaves the address cycle. Every output depends only on the current state (Moore style). An output that a state does not name is 0. The supported operations are load byte, store byte, register-register ALU operations, branch-if-equal and jump. ALU function decoding and the datapath itself live in other blocks.

Top module: `mcyc_ctrl`

## Requirements
- R1: An active-low asynchronous reset puts the sequencer in the first fetch cycle at once. It stays there until the first rising clock edge after reset is released.
- R2: Fetch takes FETCH_BYTES cycles in a row, independent of the opcode. In fetch cycle k, ir_wr_o has only bit k set. Each fetch cycle also drives mem_rd_o=1, addr_sel_o=0, alu_a_sel_o=0, alu_b_sel_o=01, alu_op_o=00, pc_wr_o=1 and pc_src_o=00.
- R3: After the last fetch cycle comes one decode cycle with alu_a_sel_o=0, alu_b_sel_o=11 and alu_op_o=00. All other outputs are 0.
- R4: Decode dispatches on opcode_i. The encodings are 100000 load byte, 101000 store byte, 000000 register ALU operation, 000100 branch-if-equal and 000010 jump. Any other opcode goes straight back to fetch cycle 0.
- R5: Load and store first spend one address cycle with alu_a_sel_o=1, alu_b_sel_o=10 and alu_op_o=00. From there a load goes to a read cycle and a store goes to a write cycle.
- R6: The load read cycle drives mem_rd_o=1 and addr_sel_o=1. It is followed by a write-back cycle with reg_wr_o=1, reg_src_mem_o=1 and dst_rd_o=0.
- R7: The store write cycle drives mem_wr_o=1 and addr_sel_o=1.
- R8: A register ALU operation takes an execute cycle (alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=10). It is followed by a completion cycle with reg_wr_o=1, dst_rd_o=1 and reg_src_mem_o=0.
- R9: Branch completion drives alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=01, pc_wr_cond_o=1 and pc_src_o=01.
- R10: Jump completion drives pc_wr_o=1 and pc_src_o=10.
- R11: After the store write, load write-back, ALU completion, branch completion or jump completion cycle, the next cycle is fetch cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_o | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| ir_wr_o | output | FETCH_BYTES | Instruction register byte write strobes |
| reg_src_mem_o | output | 1 | Register write data: 0 ALU result, 1 memory data |
| dst_rd_o | output | 1 | Destination register field: 0 rt, 1 rd |
| reg_wr_o | output | 1 | Register file write enable |
| alu_a_sel_o | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel_o | output | 2 | ALU operand B: 00 register B, 01 constant one, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_src_o | output | 2 | Next PC: 00 ALU result, 01 ALU result register, 10 jump target |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when the ALU zero flag is set |

## Verification
Some properties are checked on every cycle from the output strobes alone. These are: the byte strobes are one-hot and move up one bit per cycle, each fetch cycle increments the PC, decode follows the last fetch strobe, a store write is always preceded by an address cycle, a branch never writes the PC unconditionally, and every terminal cycle is followed by fetch cycle 0. Other behaviour only shows up in the bench's scenarios. These are the opcode-dependent dispatch, including the fall-back for all 59 undefined opcodes, the exact control word of every state, the opcode being ignored during fetch, and an asynchronous reset taken in the middle of an instruction. The bench sweeps all 64 opcodes to cover them.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_LB    = 6'b100000;
  localparam logic [OPC_W-1:0] OP_SB    = 6'b101000;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OP_J     = 6'b000010;

  localparam logic [1:0] BSEL_REG    = 2'b00;
  localparam logic [1:0] BSEL_ONE    = 2'b01;
  localparam logic [1:0] BSEL_IMM    = 2'b10;
  localparam logic [1:0] BSEL_IMM_SH = 2'b11;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_ALUREG = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;

  typedef enum logic [3:0] {
    S_FETCH,
    S_DECODE,
    S_ADDR,
    S_LD_READ,
    S_LD_WB,
    S_ST_WRITE,
    S_RT_EXEC,
    S_RT_DONE,
    S_BR_DONE,
    S_JMP_DONE
  } state_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       reg_src_mem;
    logic       dst_rd;
    logic       reg_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       pc_wr;
    logic       pc_wr_cond;
  } ctrl_t;

endpackage

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
  import mcyc_ctrl_pkg::*;
#(
  parameter int FETCH_BYTES = 4,
  localparam int IDX_W = (FETCH_BYTES > 1) ? $clog2(FETCH_BYTES) : 1
) (
  input  state_e           state_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OPC_W-1:0] opcode_i,
  output state_e           state_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FETCH_BYTES - 1);

  always_comb begin
    state_o = S_FETCH;
    idx_o   = '0;
    unique case (state_i)
      S_FETCH: begin
        if (idx_i == IDX_LAST) begin
          state_o = S_DECODE;
        end else begin
          state_o = S_FETCH;
          idx_o   = idx_i + 1'b1;
        end
      end
      S_DECODE: begin
        unique case (opcode_i)
          OP_LB, OP_SB: state_o = S_ADDR;
          OP_RTYPE:     state_o = S_RT_EXEC;
          OP_BEQ:       state_o = S_BR_DONE;
          OP_J:         state_o = S_JMP_DONE;
          default:      state_o = S_FETCH;
        endcase
      end
      S_ADDR:    state_o = (opcode_i == OP_SB) ? S_ST_WRITE : S_LD_READ;
      S_LD_READ: state_o = S_LD_WB;
      S_RT_EXEC: state_o = S_RT_DONE;
      default:   state_o = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_out_decode.sv
module mcyc_out_decode
  import mcyc_ctrl_pkg::*;
#(
  parameter int FETCH_BYTES = 4,
  localparam int IDX_W = (FETCH_BYTES > 1) ? $clog2(FETCH_BYTES) : 1
) (
  input  state_e                 state_i,
  input  logic [IDX_W-1:0]       idx_i,
  output ctrl_t                  ctrl_o,
  output logic [FETCH_BYTES-1:0] ir_wr_o
);

  for (genvar g = 0; g < FETCH_BYTES; g++) begin : g_irwr
    assign ir_wr_o[g] = (state_i == S_FETCH) && (idx_i == IDX_W'(g));
  end

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      S_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.alu_b_sel = BSEL_ONE;
        ctrl_o.alu_op    = AOP_ADD;
        ctrl_o.pc_src    = PCS_ALU;
        ctrl_o.pc_wr     = 1'b1;
      end
      S_DECODE: begin
        ctrl_o.alu_b_sel = BSEL_IMM_SH;
        ctrl_o.alu_op    = AOP_ADD;
      end
      S_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_IMM;
        ctrl_o.alu_op    = AOP_ADD;
      end
      S_LD_READ: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_LD_WB: begin
        ctrl_o.reg_wr      = 1'b1;
        ctrl_o.reg_src_mem = 1'b1;
      end
      S_ST_WRITE: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_RT_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_REG;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      S_RT_DONE: begin
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.dst_rd = 1'b1;
      end
      S_BR_DONE: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = BSEL_REG;
        ctrl_o.alu_op     = AOP_SUB;
        ctrl_o.pc_src     = PCS_ALUREG;
        ctrl_o.pc_wr_cond = 1'b1;
      end
      S_JMP_DONE: begin
        ctrl_o.pc_src = PCS_JUMP;
        ctrl_o.pc_wr  = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
#(
  parameter int FETCH_BYTES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [5:0]             opcode_i,
  output logic                   mem_rd_o,
  output logic                   mem_wr_o,
  output logic                   addr_sel_o,
  output logic [FETCH_BYTES-1:0] ir_wr_o,
  output logic                   reg_src_mem_o,
  output logic                   dst_rd_o,
  output logic                   reg_wr_o,
  output logic                   alu_a_sel_o,
  output logic [1:0]             alu_b_sel_o,
  output logic [1:0]             alu_op_o,
  output logic [1:0]             pc_src_o,
  output logic                   pc_wr_o,
  output logic                   pc_wr_cond_o
);

  localparam int IDX_W = (FETCH_BYTES > 1) ? $clog2(FETCH_BYTES) : 1;

  state_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  ctrl_t            ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  mcyc_next_state #(.FETCH_BYTES(FETCH_BYTES)) u_nxt (
    .state_i  (state_q),
    .idx_i    (idx_q),
    .opcode_i (opcode_i),
    .state_o  (state_d),
    .idx_o    (idx_d)
  );

  mcyc_out_decode #(.FETCH_BYTES(FETCH_BYTES)) u_dec (
    .state_i (state_q),
    .idx_i   (idx_q),
    .ctrl_o  (ctrl),
    .ir_wr_o (ir_wr_o)
  );

  assign mem_rd_o      = ctrl.mem_rd;
  assign mem_wr_o      = ctrl.mem_wr;
  assign addr_sel_o    = ctrl.addr_sel;
  assign reg_src_mem_o = ctrl.reg_src_mem;
  assign dst_rd_o      = ctrl.dst_rd;
  assign reg_wr_o      = ctrl.reg_wr;
  assign alu_a_sel_o   = ctrl.alu_a_sel;
  assign alu_b_sel_o   = ctrl.alu_b_sel;
  assign alu_op_o      = ctrl.alu_op;
  assign pc_src_o      = ctrl.pc_src;
  assign pc_wr_o       = ctrl.pc_wr;
  assign pc_wr_cond_o  = ctrl.pc_wr_cond;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk #(
  parameter int FETCH_BYTES = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mem_rd_o,
  input logic                   mem_wr_o,
  input logic                   addr_sel_o,
  input logic [FETCH_BYTES-1:0] ir_wr_o,
  input logic                   reg_src_mem_o,
  input logic                   dst_rd_o,
  input logic                   reg_wr_o,
  input logic                   alu_a_sel_o,
  input logic [1:0]             alu_b_sel_o,
  input logic [1:0]             pc_src_o,
  input logic                   pc_wr_o,
  input logic                   pc_wr_cond_o
);

  a_r2_irwr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ir_wr_o));

  a_r2_fetch_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_wr_o != '0 && !ir_wr_o[FETCH_BYTES-1]) |=> (ir_wr_o == ($past(ir_wr_o) << 1)));

  a_r2_fetch_pc_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_wr_o != '0) |-> (pc_wr_o && mem_rd_o && !addr_sel_o && alu_b_sel_o == 2'b01));

  a_r3_decode_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o[FETCH_BYTES-1] |=> (ir_wr_o == '0 && alu_b_sel_o == 2'b11 && !mem_rd_o && !pc_wr_o));

  a_r5_store_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(alu_a_sel_o && alu_b_sel_o == 2'b10));

  a_r7_store_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (addr_sel_o && !mem_rd_o && !reg_wr_o));

  a_r6_wb_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_src_mem_o) |-> !dst_rd_o);

  a_r9_branch_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |-> (!pc_wr_o && pc_src_o == 2'b01));

  a_r11_return_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || mem_wr_o || pc_wr_cond_o || (pc_wr_o && pc_src_o == 2'b10))
      |=> ir_wr_o[0]);

endmodule

bind mcyc_ctrl mcyc_ctrl_chk #(.FETCH_BYTES(FETCH_BYTES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .addr_sel_o    (addr_sel_o),
  .ir_wr_o       (ir_wr_o),
  .reg_src_mem_o (reg_src_mem_o),
  .dst_rd_o      (dst_rd_o),
  .reg_wr_o      (reg_wr_o),
  .alu_a_sel_o   (alu_a_sel_o),
  .alu_b_sel_o   (alu_b_sel_o),
  .pc_src_o      (pc_src_o),
  .pc_wr_o       (pc_wr_o),
  .pc_wr_cond_o  (pc_wr_cond_o)
);

// File: tb/mcyc_ctrl_tb.sv
`timescale 1ns/1ps
module mcyc_ctrl_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'd0;
  logic       mem_rd_o, mem_wr_o, addr_sel_o, reg_src_mem_o, dst_rd_o, reg_wr_o;
  logic       alu_a_sel_o, pc_wr_o, pc_wr_cond_o;
  logic [3:0] ir_wr_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_src_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  mcyc_ctrl #(.FETCH_BYTES(4)) u_dut (
    .clk_i, .rst_ni, .opcode_i, .mem_rd_o, .mem_wr_o, .addr_sel_o, .ir_wr_o,
    .reg_src_mem_o, .dst_rd_o, .reg_wr_o, .alu_a_sel_o, .alu_b_sel_o,
    .alu_op_o, .pc_src_o, .pc_wr_o, .pc_wr_cond_o
  );

  wire [18:0] act = {mem_rd_o, mem_wr_o, addr_sel_o, ir_wr_o, reg_src_mem_o,
                     dst_rd_o, reg_wr_o, alu_a_sel_o, alu_b_sel_o, alu_op_o,
                     pc_src_o, pc_wr_o, pc_wr_cond_o};

  function automatic logic [18:0] mk(input logic mr, mw, ids, input logic [3:0] irw,
                                     input logic m2r, rd, rw, asa,
                                     input logic [1:0] asb, aop, psrc,
                                     input logic pw, pwc);
    return {mr, mw, ids, irw, m2r, rd, rw, asa, asb, aop, psrc, pw, pwc};
  endfunction

  // step ids: 0..3 fetch byte, 4 decode, 5 addr, 6 load read, 7 write-back,
  // 8 store write, 9 alu exec, 10 alu done, 11 branch, 12 jump
  function automatic logic [18:0] expect_of(input int id);
    case (id)
      0, 1, 2, 3: return mk(1, 0, 0, 4'(1 << id), 0, 0, 0, 0, 2'b01, 2'b00, 2'b00, 1, 0);
      4:  return mk(0, 0, 0, 4'b0, 0, 0, 0, 0, 2'b11, 2'b00, 2'b00, 0, 0);
      5:  return mk(0, 0, 0, 4'b0, 0, 0, 0, 1, 2'b10, 2'b00, 2'b00, 0, 0);
      6:  return mk(1, 0, 1, 4'b0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0);
      7:  return mk(0, 0, 0, 4'b0, 1, 0, 1, 0, 2'b00, 2'b00, 2'b00, 0, 0);
      8:  return mk(0, 1, 1, 4'b0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0);
      9:  return mk(0, 0, 0, 4'b0, 0, 0, 0, 1, 2'b00, 2'b10, 2'b00, 0, 0);
      10: return mk(0, 0, 0, 4'b0, 0, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, 0);
      11: return mk(0, 0, 0, 4'b0, 0, 0, 0, 1, 2'b00, 2'b01, 2'b01, 0, 1);
      12: return mk(0, 0, 0, 4'b0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b10, 1, 0);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input int id);
    logic [18:0] exp_v;
    exp_v = expect_of(id);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s step %0d op %b: actual %b expected %b", req, id, opcode_i, act, exp_v);
    end
  endtask

  // at a negedge in fetch byte 0; leaves at a negedge in the next fetch byte 0
  task automatic run_instr(input logic [5:0] op, input string first_req);
    int path[3];
    int n;
    string tags[3];
    for (int k = 0; k < 4; k++) begin
      opcode_i = ~op;
      chk((k == 0) ? first_req : "R2", k);
      if (k == 3) opcode_i = op;
      @(negedge clk_i);
    end
    chk("R3", 4);
    n = 0;
    case (op)
      6'b100000: begin path = '{5, 6, 7};   tags = '{"R5", "R6", "R6"}; n = 3; end
      6'b101000: begin path = '{5, 8, 0};   tags = '{"R5", "R7", ""};   n = 2; end
      6'b000000: begin path = '{9, 10, 0};  tags = '{"R8", "R8", ""};   n = 2; end
      6'b000100: begin path = '{11, 0, 0};  tags = '{"R9", "", ""};     n = 1; end
      6'b000010: begin path = '{12, 0, 0};  tags = '{"R10", "", ""};    n = 1; end
      default: n = 0;
    endcase
    for (int s = 0; s < n; s++) begin
      @(negedge clk_i);
      chk(tags[s], path[s]);
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", 0);
    rst_ni = 1'b1;
    // still fetch byte 0 before the first edge (R1)
    chk("R1", 0);
    run_instr(6'b100000, "R1");
    // sweep every opcode; undefined ones must fall back to fetch (R4)
    for (int op = 0; op < 64; op++) begin
      logic [5:0] o;
      o = 6'(op);
      if (o == 6'b100000 || o == 6'b101000 || o == 6'b000000 ||
          o == 6'b000100 || o == 6'b000010)
        run_instr(o, "R11");
      else
        run_instr(o, "R4");
    end
    chk("R11", 0);
    // asynchronous reset in the middle of a load (R1)
    for (int k = 0; k < 5; k++) begin
      opcode_i = 6'b100000;
      @(negedge clk_i);
    end
    chk("R5", 5);
    #0.5 rst_ni = 1'b0;
    #0.5 chk("R1", 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_instr(6'b101000, "R1");
    run_instr(6'b000010, "R11");
    chk("R11", 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule